// File: doc/BRIEF.md
# Dual-Channel Wiper Register Command Engine

This block is the command core of a two-channel digital potentiometer. Each channel has one volatile 8-bit wiper code, which drives the tap selection downstream. Each channel also has four 8-bit data slots that model nonvolatile storage. The engine sits behind a bus front end that works at byte level. That front end reports START and STOP as one-cycle pulses and delivers the bytes it receives on a valid/ready stream. For each byte it gets back an ACK/NACK decision. Bytes that the host reads come out on a second valid/ready stream.

A transaction starts with an address byte, followed by an instruction byte. Write commands then carry one data byte. The instruction can:
- read or write a wiper or a data slot;
- copy between a wiper and a data slot, on one channel or on both channels together;
- enter a stepping mode, in which the front end nudges the wiper up or down one code at a time.

Any command that changes a data slot is only staged when its byte is accepted. The STOP that follows opens a busy interval of a fixed number of cycles, and the slot is written when that interval ends. An active-low protect input blocks data-slot changes and never blocks wiper changes. After reset, each wiper is restored from slot 0 of its own channel.

Back-pressure rules: `rx_ready` is low only while a read byte is waiting on the transmit stream. A receive byte is consumed on the cycle where both `rx_valid` and `rx_ready` are high. Exactly one cycle later `ack_valid` pulses, and `ack_ok` carries the decision. `tx_valid` stays high with `tx_data` unchanged until `tx_ready` is seen.

Top module: `wiper_cmd_engine`

## Requirements
- R1: While reset is active the wipers read zero and `busy` is high. On the first clock edge after reset is released, each wiper loads slot 0 of its own channel, and `busy` falls at the same edge.
- R2: The first byte after a START is acknowledged only when all three hold: bits 7:4 equal 0101, bits 3:0 equal `dev_addr`, and the block is not busy. Otherwise that byte and every later byte of the frame get NACK and change nothing.
- R3: Instruction byte layout:
  - bits 7:4 are the opcode, bits 3:2 select the data slot, bits 1:0 select the channel;
  - 1001 reads a wiper and 1010 writes a wiper;
  - 1011 reads a slot and 1100 writes a slot;
  - 1101 copies slot to wiper and 1110 copies wiper to slot;
  - 0001 copies slot to wiper on both channels and 1000 copies wiper to slot on both channels;
  - 0010 enters stepping mode.
- R4: After an acknowledged read instruction, the one-cycle `ack_valid` pulse and the rising `tx_valid` appear together. `tx_data` holds the selected value, and both stay unchanged until `tx_ready` is seen.
- R5: A wiper write (opcode 1010) acknowledges its data byte and updates the wiper at once, whatever the level of `wp_n`. It never starts a busy interval.
- R6: After an acknowledged slot write, the STOP raises `busy` for exactly COMMIT_CYCLES cycles. The slot holds its old value until `busy` falls and shows the new value after that.
- R7: While `wp_n` is low, these are all NACKed and no slot changes:
  - the data byte of a slot write;
  - a single wiper-to-slot copy;
  - a gang wiper-to-slot copy.
- R8: If `wp_n` goes low after a slot change has been accepted but before its STOP, no busy interval starts and the slot keeps its value. If `wp_n` goes low during the busy interval, the write still completes.
- R9: A single slot-to-wiper copy (1101) loads the selected channel's wiper immediately. A single wiper-to-slot copy (1110) stages the selected wiper value for the selected slot.
- R10: The gang copies (0001 and 1000) act on the chosen slot of every channel at once and are accepted only when bits 1:0 are 00. Any other value is NACKed.
- R11: In stepping mode, each `step_valid` cycle moves the selected wiper by one code: up when `step_up` is 1, down when it is 0. The code stops at 255 and at 0. `step_valid` outside stepping mode has no effect.
- R12: The instruction byte is NACKed and nothing changes when either holds: the opcode is not one of the nine in R3, or the channel field is not below the channel count. Any later bytes in the same frame are also NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 4 | Strapped device address compared with the low nibble of the address byte |
| wp_n | input | 1 | Active-low protect for the data slots |
| bus_start | input | 1 | One-cycle pulse: START seen on the bus |
| bus_stop | input | 1 | One-cycle pulse: STOP seen on the bus |
| rx_valid | input | 1 | Received byte is valid |
| rx_ready | output | 1 | Engine can take a received byte |
| rx_data | input | W | Received byte |
| ack_valid | output | 1 | One-cycle pulse carrying the decision for the last byte |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| tx_valid | output | 1 | Read byte available |
| tx_ready | input | 1 | Front end takes the read byte |
| tx_data | output | W | Read byte |
| step_valid | input | 1 | One step request while in stepping mode |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| busy | output | 1 | Reset recall or slot commit in progress |
| wiper_code | output | NCH*W | Wiper codes, channel c at bits c*W +: W |

## Verification
The hardest condition to reach is the protect input falling in the narrow gap between an accepted slot write and its STOP. The bench gets there by driving the full three-byte write and holding the frame open. It then lowers `wp_n` before pulsing STOP, and confirms that `busy` never rises and that a later read returns the old value. It repeats the write with `wp_n` falling only after `busy` has risen, to show that the same input is ignored once the commit is under way.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;

  // Instruction opcodes carried in bits 7:4 of the instruction byte
  typedef enum logic [3:0] {
    OP_GANG_D2W = 4'b0001,
    OP_STEP     = 4'b0010,
    OP_GANG_W2D = 4'b1000,
    OP_RD_W     = 4'b1001,
    OP_WR_W     = 4'b1010,
    OP_RD_D     = 4'b1011,
    OP_WR_D     = 4'b1100,
    OP_D2W      = 4'b1101,
    OP_W2D      = 4'b1110
  } opc_e;

  // Frame sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_DATA,
    ST_SEND,
    ST_STEP,
    ST_SKIP
  } seq_e;

  localparam logic [3:0] DEV_TYPE = 4'b0101;

endpackage

// File: rtl/potcmd_decode.sv
module potcmd_decode
  import potcmd_pkg::*;
#(
  parameter int NCH = 2,
  parameter int NDR = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic [7:0]    byte_i,
  output logic          legal_o,
  output opc_e          op_o,
  output logic [CW-1:0] ch_o,
  output logic [SW-1:0] sel_o
);

  logic [1:0] psel;
  logic [1:0] dsel;
  logic       ch_ok;

  always_comb begin
    psel    = byte_i[1:0];
    dsel    = byte_i[3:2];
    op_o    = opc_e'(byte_i[7:4]);
    ch_o    = CW'(psel);
    sel_o   = SW'(dsel);
    ch_ok   = (int'(psel) < NCH);
    legal_o = 1'b0;
    case (op_o)
      OP_RD_W, OP_WR_W, OP_RD_D, OP_WR_D,
      OP_D2W, OP_W2D, OP_STEP:   legal_o = ch_ok;
      OP_GANG_D2W, OP_GANG_W2D:  legal_o = (psel == 2'b00);
      default:                   legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/potcmd_regs.sv
module potcmd_regs #(
  parameter int NCH = 2,
  parameter int NDR = 4,
  parameter int W   = 8,
  parameter logic [NCH*NDR*W-1:0] DR_INIT = '0,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  // direct wiper write
  input  logic               wr_en,
  input  logic [CW-1:0]      wr_ch,
  input  logic [W-1:0]       wr_val,
  // slot-to-wiper load (per channel mask)
  input  logic [NCH-1:0]     ld_mask,
  input  logic [SW-1:0]      ld_sel,
  // stepping
  input  logic               st_en,
  input  logic [CW-1:0]      st_ch,
  input  logic               st_up,
  // slot commit
  input  logic               cm_en,
  input  logic [NCH-1:0]     cm_mask,
  input  logic [SW-1:0]      cm_sel,
  input  logic [NCH*W-1:0]   cm_data,
  // read port
  input  logic [CW-1:0]      rd_ch,
  input  logic [SW-1:0]      rd_sel,
  output logic [W-1:0]       rd_wiper,
  output logic [W-1:0]       rd_dr,
  output logic [NCH*W-1:0]   wiper_o,
  output logic [NCH*NDR*W-1:0] dr_o
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] wip;
    logic [W-1:0] slot [NDR];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wip <= '0;
        for (int k = 0; k < NDR; k++) slot[k] <= DR_INIT[(c*NDR+k)*W +: W];
      end else begin
        if (ld_mask[c]) begin
          wip <= slot[ld_sel];
        end else if (wr_en && (wr_ch == CW'(c))) begin
          wip <= wr_val;
        end else if (st_en && (st_ch == CW'(c))) begin
          if (st_up) begin
            if (wip != MAXV) wip <= wip + 1'b1;
          end else begin
            if (wip != '0) wip <= wip - 1'b1;
          end
        end
        if (cm_en && cm_mask[c]) slot[cm_sel] <= cm_data[c*W +: W];
      end
    end

    assign wiper_o[c*W +: W] = wip;
    for (genvar k = 0; k < NDR; k++) begin : g_slot
      assign dr_o[(c*NDR+k)*W +: W] = slot[k];
    end
  end

  always_comb begin
    rd_wiper = wiper_o[int'(rd_ch)*W +: W];
    rd_dr    = dr_o[(int'(rd_ch)*NDR + int'(rd_sel))*W +: W];
  end

endmodule

// File: rtl/potcmd_commit.sv
module potcmd_commit #(
  parameter int NCH = 2,
  parameter int W   = 8,
  parameter int SW  = 2,
  parameter int CYC = 200,
  localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             frame_start,
  input  logic             frame_stop,
  input  logic             arm,
  input  logic [NCH-1:0]   arm_mask,
  input  logic [SW-1:0]    arm_sel,
  input  logic [NCH*W-1:0] arm_data,
  output logic             busy,
  output logic             cm_en,
  output logic [NCH-1:0]   cm_mask,
  output logic [SW-1:0]    cm_sel,
  output logic [NCH*W-1:0] cm_data
);

  logic             pend;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      cm_mask <= '0;
      cm_sel  <= '0;
      cm_data <= '0;
    end else if (busy) begin
      // protect input has no say once the interval runs
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (frame_stop && pend && wp_n) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(CYC - 1);
      pend <= 1'b0;
    end else if (frame_start || !wp_n) begin
      pend <= 1'b0;
    end else if (arm) begin
      pend    <= 1'b1;
      cm_mask <= arm_mask;
      cm_sel  <= arm_sel;
      cm_data <= arm_data;
    end
  end

  assign cm_en = busy && (cnt == '0);

endmodule

// File: rtl/wiper_cmd_engine.sv
module wiper_cmd_engine
  import potcmd_pkg::*;
#(
  parameter int NCH = 2,
  parameter int NDR = 4,
  parameter int W   = 8,
  parameter int COMMIT_CYCLES = 200,
  parameter logic [NCH*NDR*W-1:0] DR_INIT = 64'h332211A5_73625140,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       dev_addr,
  input  logic             wp_n,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [W-1:0]     rx_data,
  output logic             ack_valid,
  output logic             ack_ok,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [W-1:0]     tx_data,
  input  logic             step_valid,
  input  logic             step_up,
  output logic             busy,
  output logic [NCH*W-1:0] wiper_code
);

  seq_e          state;
  opc_e          op_q;
  logic [CW-1:0] ch_q;
  logic [SW-1:0] sel_q;
  logic          recall_q;

  // decoder
  logic          d_legal;
  opc_e          d_op;
  logic [CW-1:0] d_ch;
  logic [SW-1:0] d_sel;

  potcmd_decode #(.NCH(NCH), .NDR(NDR)) u_dec (
    .byte_i (rx_data[7:0]),
    .legal_o(d_legal),
    .op_o   (d_op),
    .ch_o   (d_ch),
    .sel_o  (d_sel)
  );

  // register file hookup
  logic                 wr_en;
  logic [NCH-1:0]       ld_mask;
  logic [SW-1:0]        ld_sel;
  logic                 st_en;
  logic                 cm_en;
  logic                 cm_busy;
  logic [NCH-1:0]       cm_mask;
  logic [SW-1:0]        cm_sel;
  logic [NCH*W-1:0]     cm_data;
  logic [W-1:0]         rd_wiper;
  logic [W-1:0]         rd_dr;
  logic [NCH*NDR*W-1:0] dr_flat;
  logic                 in_step;

  // staging for the commit unit
  logic                 arm;
  logic [NCH-1:0]       arm_mask;
  logic [SW-1:0]        arm_sel;
  logic [NCH*W-1:0]     arm_data;

  logic                 rx_fire;
  logic                 byte_go;
  logic                 byte_ok;
  logic                 tx_load;
  seq_e                 nxt;
  logic [NCH-1:0]       onehot_d;
  logic [NCH-1:0]       onehot_q;

  assign rx_ready = !tx_valid;
  assign rx_fire  = rx_valid && rx_ready;
  assign byte_go  = rx_fire && !bus_start && !bus_stop;
  assign in_step  = (state == ST_STEP);
  assign st_en    = step_valid && in_step;
  assign busy     = cm_busy || recall_q;

  always_comb begin
    onehot_d = '0;
    onehot_d[d_ch] = 1'b1;
    onehot_q = '0;
    onehot_q[ch_q] = 1'b1;
  end

  always_comb begin
    byte_ok  = 1'b0;
    nxt      = ST_SKIP;
    wr_en    = 1'b0;
    tx_load  = 1'b0;
    arm      = 1'b0;
    arm_mask = '0;
    arm_sel  = d_sel;
    arm_data = {NCH{rd_wiper}};
    ld_mask  = '0;
    ld_sel   = d_sel;
    if (recall_q) begin
      ld_mask = '1;
      ld_sel  = '0;
    end else if (byte_go) begin
      case (state)
        ST_ADDR: begin
          byte_ok = (rx_data[7:4] == DEV_TYPE) && (rx_data[3:0] == dev_addr) && !cm_busy;
          nxt     = byte_ok ? ST_INSTR : ST_SKIP;
        end
        ST_INSTR: begin
          if (d_legal) begin
            case (d_op)
              OP_RD_W, OP_RD_D: begin
                byte_ok = 1'b1;
                tx_load = 1'b1;
                nxt     = ST_SEND;
              end
              OP_WR_W, OP_WR_D: begin
                byte_ok = 1'b1;
                nxt     = ST_DATA;
              end
              OP_D2W: begin
                byte_ok = 1'b1;
                ld_mask = onehot_d;
              end
              OP_GANG_D2W: begin
                byte_ok = 1'b1;
                ld_mask = '1;
              end
              OP_W2D: begin
                byte_ok  = wp_n;
                arm      = wp_n;
                arm_mask = onehot_d;
              end
              OP_GANG_W2D: begin
                byte_ok  = wp_n;
                arm      = wp_n;
                arm_mask = '1;
                arm_data = wiper_code;
              end
              OP_STEP: begin
                byte_ok = 1'b1;
                nxt     = ST_STEP;
              end
              default: byte_ok = 1'b0;
            endcase
          end
        end
        ST_DATA: begin
          if (op_q == OP_WR_W) begin
            byte_ok = 1'b1;
            wr_en   = 1'b1;
          end else begin
            byte_ok  = wp_n;
            arm      = wp_n;
            arm_mask = onehot_q;
            arm_sel  = sel_q;
            arm_data = {NCH{rx_data}};
          end
        end
        default: begin
          byte_ok = 1'b0;
          nxt     = (state == ST_STEP) ? ST_STEP : ST_SKIP;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_q      <= OP_RD_W;
      ch_q      <= '0;
      sel_q     <= '0;
      recall_q  <= 1'b1;
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      recall_q  <= 1'b0;
      ack_valid <= rx_fire;
      ack_ok    <= byte_go && byte_ok;
      if (bus_start)    state <= ST_ADDR;
      else if (bus_stop) state <= ST_IDLE;
      else if (tx_valid && tx_ready) state <= ST_SKIP;
      else if (byte_go) state <= nxt;
      if (byte_go && state == ST_INSTR) begin
        op_q  <= d_op;
        ch_q  <= d_ch;
        sel_q <= d_sel;
      end
      if (bus_start || bus_stop || (tx_valid && tx_ready)) begin
        tx_valid <= 1'b0;
      end else if (tx_load) begin
        tx_valid <= 1'b1;
        tx_data  <= (d_op == OP_RD_W) ? rd_wiper : rd_dr;
      end
    end
  end

  potcmd_regs #(.NCH(NCH), .NDR(NDR), .W(W), .DR_INIT(DR_INIT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ch   (ch_q),
    .wr_val  (rx_data),
    .ld_mask (ld_mask),
    .ld_sel  (ld_sel),
    .st_en   (st_en),
    .st_ch   (ch_q),
    .st_up   (step_up),
    .cm_en   (cm_en),
    .cm_mask (cm_mask),
    .cm_sel  (cm_sel),
    .cm_data (cm_data),
    .rd_ch   (d_ch),
    .rd_sel  (d_sel),
    .rd_wiper(rd_wiper),
    .rd_dr   (rd_dr),
    .wiper_o (wiper_code),
    .dr_o    (dr_flat)
  );

  potcmd_commit #(.NCH(NCH), .W(W), .SW(SW), .CYC(COMMIT_CYCLES)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n       (wp_n),
    .frame_start(bus_start),
    .frame_stop (bus_stop),
    .arm        (arm),
    .arm_mask   (arm_mask),
    .arm_sel    (arm_sel),
    .arm_data   (arm_data),
    .busy       (cm_busy),
    .cm_en      (cm_en),
    .cm_mask    (cm_mask),
    .cm_sel     (cm_sel),
    .cm_data    (cm_data)
  );

endmodule

// File: rtl/wiper_cmd_engine_sva.sv
module wiper_cmd_engine_sva #(
  parameter int NCH = 2,
  parameter int NDR = 4,
  parameter int W   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wp_n,
  input logic                 bus_start,
  input logic                 bus_stop,
  input logic                 rx_valid,
  input logic                 rx_ready,
  input logic                 ack_valid,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic [W-1:0]         tx_data,
  input logic                 step_valid,
  input logic                 step_up,
  input logic [NCH*W-1:0]     wiper_code,
  input logic                 arm,
  input logic                 cm_busy,
  input logic                 cm_en,
  input logic [NCH*NDR*W-1:0] dr_flat,
  input logic                 in_step
);

  // R2: a decision only follows a consumed byte
  p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(rx_valid && rx_ready));

  // R4: a waiting read byte is held
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_start && !bus_stop) |=> (tx_valid && $stable(tx_data)));

  // R6: slots move only on the commit cycle
  p_slot_only_on_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_en |=> $stable(dr_flat));

  // R6: every busy interval ends with a commit
  p_busy_ends_in_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cm_busy) |-> $past(cm_en));

  // R7: nothing is staged while protected
  p_no_stage_when_protected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> wp_n);

  // R11: codes at the top stay at the top
  p_step_top_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_step && step_valid && step_up && (&wiper_code)) |=> (&wiper_code));

endmodule

bind wiper_cmd_engine wiper_cmd_engine_sva #(.NCH(NCH), .NDR(NDR), .W(W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_n      (wp_n),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .ack_valid (ack_valid),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .step_valid(step_valid),
  .step_up   (step_up),
  .wiper_code(wiper_code),
  .arm       (arm),
  .cm_busy   (cm_busy),
  .cm_en     (cm_en),
  .dr_flat   (dr_flat),
  .in_step   (in_step)
);

// File: tb/test_wiper_cmd_engine.sv
module test_wiper_cmd_engine;

  localparam int CYC = 16;
  localparam logic [7:0] ADDR = 8'h59;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dev_addr = 4'h9;
  logic        wp_n = 1'b1;
  logic        bus_start = 1'b0;
  logic        bus_stop = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        ack_valid;
  logic        ack_ok;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        step_valid = 1'b0;
  logic        step_up = 1'b0;
  logic        busy;
  logic [15:0] wiper_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wiper_cmd_engine #(.COMMIT_CYCLES(CYC)) i_wiper_cmd_engine (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .wp_n(wp_n),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ack_valid(ack_valid), .ack_ok(ack_ok),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .step_valid(step_valid), .step_up(step_up),
    .busy(busy), .wiper_code(wiper_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_f();
    bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic stop_f();
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output bit ok);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    ok = ack_valid && ack_ok;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  // address + instruction (+ data when three_b), then STOP
  task automatic cmd(input logic [7:0] ins, input bit three_b, input logic [7:0] d,
                     output bit a_ins, output bit a_dat);
    bit a_adr;
    start_f();
    send(ADDR, a_adr);
    send(ins, a_ins);
    a_dat = 1'b0;
    if (three_b) send(d, a_dat);
    stop_f();
  endtask

  task automatic read_b(input logic [7:0] ins, output logic [7:0] v);
    bit a;
    start_f();
    send(ADDR, a);
    send(ins, a);
    v = tx_valid ? tx_data : 8'hxx;
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    stop_f();
  endtask

  task automatic step(input bit up, input int n);
    for (int i = 0; i < n; i++) begin
      step_valid = 1'b1; step_up = up; @(negedge clk);
    end
    step_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 wipers in reset", wiper_code, 16'h0000);
    check("R1 busy in reset", busy, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wiper0 recalled", wiper_code[7:0], 8'h40);
    check("R1 wiper1 recalled", wiper_code[15:8], 8'hA5);
    check("R1 busy after recall", busy, 0);
    check("R4 tx idle", tx_valid, 0);
  endtask

  task automatic t_addr();
    bit a;
    start_f(); send(8'h5A, a); check("R2 wrong device nack", a, 0); stop_f();
    start_f(); send(8'h69, a); check("R2 wrong type nack", a, 0);
    send(8'hA1, a); check("R2 rest of frame nack", a, 0); stop_f();
    check("R2 nothing changed", wiper_code, 16'hA540);
    start_f(); send(ADDR, a); check("R2 match ack", a, 1); stop_f();
  endtask

  task automatic t_wiper_write();
    bit ai, ad;
    wp_n = 1'b0;
    cmd(8'hA1, 1, 8'h77, ai, ad);   // R3 opcode 1010 ch 01
    check("R3 write wiper instr ack", ai, 1);
    check("R5 data ack under protect", ad, 1);
    check("R5 wiper1 updated", wiper_code[15:8], 8'h77);
    check("R5 wiper0 untouched", wiper_code[7:0], 8'h40);
    check("R5 no busy", busy, 0);
    wp_n = 1'b1;
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] v;
    start_f(); send(ADDR, a); send(8'hB9, a);
    check("R4 read instr ack", a, 1);
    check("R4 tx valid", tx_valid, 1);
    check("R4 slot ch1/2 value", tx_data, 8'h22);
    check("R4 rx stalled", rx_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R4 hold valid", tx_valid, 1);
      check("R4 hold data", tx_data, 8'h22);
    end
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    check("R4 released", tx_valid, 0);
    stop_f();
    read_b(8'h90, v);
    check("R4 read wiper0", v, 8'h40);
  endtask

  task automatic t_slot_write();
    bit ai, ad, a;
    logic [7:0] v;
    cmd(8'hCC, 1, 8'h9E, ai, ad);
    check("R6 slot write acks", {ai, ad}, 2'b11);
    check("R6 busy after stop", busy, 1);
    start_f(); send(ADDR, a); check("R2 busy address nack", a, 0); stop_f();
    wait_idle();
    read_b(8'hBC, v);
    check("R6 slot value after commit", v, 8'h9E);
  endtask

  task automatic t_protect();
    bit ai, ad;
    logic [7:0] v;
    wp_n = 1'b0;
    cmd(8'hC5, 1, 8'h44, ai, ad);
    check("R7 slot data nack", ad, 0);
    check("R7 no busy", busy, 0);
    cmd(8'hE0, 0, 8'h00, ai, ad);
    check("R7 copy to slot nack", ai, 0);
    cmd(8'h80, 0, 8'h00, ai, ad);
    check("R7 gang copy to slot nack", ai, 0);
    wp_n = 1'b1;
    read_b(8'hB5, v);
    check("R7 slot unchanged", v, 8'h11);
    read_b(8'hB0, v);
    check("R7 slot ch0/0 unchanged", v, 8'h40);
  endtask

  task automatic t_wp_timing();
    bit a, ai, ad;
    logic [7:0] v;
    start_f(); send(ADDR, a); send(8'hC4, ai); send(8'h5C, ad);
    check("R8 write accepted", ad, 1);
    wp_n = 1'b0; @(negedge clk);
    stop_f();
    check("R8 cancelled no busy", busy, 0);
    wp_n = 1'b1;
    read_b(8'hB4, v);
    check("R8 cancelled slot kept", v, 8'h51);
    cmd(8'hC4, 1, 8'h5C, ai, ad);
    check("R8 busy started", busy, 1);
    wp_n = 1'b0;
    wait_idle();
    wp_n = 1'b1;
    read_b(8'hB4, v);
    check("R8 late protect ignored", v, 8'h5C);
  endtask

  task automatic t_single_xfer();
    bit ai, ad;
    int n;
    logic [7:0] v;
    cmd(8'hD8, 0, 8'h00, ai, ad);
    check("R9 slot to wiper ack", ai, 1);
    check("R9 wiper0 loaded", wiper_code[7:0], 8'h62);
    cmd(8'hA1, 1, 8'h3C, ai, ad);
    cmd(8'hE1, 0, 8'h00, ai, ad);
    check("R9 wiper to slot ack", ai, 1);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check("R6 busy length", n, CYC);
    read_b(8'hB1, v);
    check("R9 slot ch1/0 = wiper1", v, 8'h3C);
  endtask

  task automatic t_gang();
    bit ai, ad;
    logic [7:0] v;
    cmd(8'h14, 0, 8'h00, ai, ad);
    check("R10 gang load ack", ai, 1);
    check("R10 both wipers from slot 1", wiper_code, 16'h115C);
    cmd(8'h15, 0, 8'h00, ai, ad);
    check("R10 nonzero channel field nack", ai, 0);
    check("R10 wipers kept", wiper_code, 16'h115C);
    cmd(8'h8C, 0, 8'h00, ai, ad);
    check("R10 gang store ack", ai, 1);
    wait_idle();
    read_b(8'hBC, v); check("R10 ch0 slot 3", v, 8'h5C);
    read_b(8'hBD, v); check("R10 ch1 slot 3", v, 8'h11);
  endtask

  task automatic t_step();
    bit a, ai, ad;
    start_f(); send(ADDR, a); send(8'h20, a);
    check("R11 step mode ack", a, 1);
    step(1, 3); check("R11 up three", wiper_code[7:0], 8'h5F);
    step(0, 1); check("R11 down one", wiper_code[7:0], 8'h5E);
    check("R11 other channel kept", wiper_code[15:8], 8'h11);
    stop_f();
    step(1, 2); check("R11 ignored outside mode", wiper_code[7:0], 8'h5E);
    cmd(8'hA0, 1, 8'hFE, ai, ad);
    start_f(); send(ADDR, a); send(8'h20, a);
    step(1, 3); check("R11 top saturation", wiper_code[7:0], 8'hFF);
    stop_f();
    cmd(8'hA0, 1, 8'h01, ai, ad);
    start_f(); send(ADDR, a); send(8'h20, a);
    step(0, 3); check("R11 bottom saturation", wiper_code[7:0], 8'h00);
    stop_f();
    start_f(); send(ADDR, a); send(8'h21, a);
    step(0, 2); check("R11 channel 1 down", wiper_code[15:8], 8'h0F);
    stop_f();
  endtask

  task automatic t_illegal();
    bit ai, ad;
    cmd(8'h30, 0, 8'h00, ai, ad);
    check("R12 undefined opcode nack", ai, 0);
    cmd(8'h00, 0, 8'h00, ai, ad);
    check("R12 zero opcode nack", ai, 0);
    cmd(8'hA2, 1, 8'h55, ai, ad);
    check("R12 channel 2 nack", ai, 0);
    check("R12 trailing byte nack", ad, 0);
    check("R12 wipers unchanged", wiper_code, 16'h0F00);
    check("R12 no busy", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_addr();
    t_wiper_write();
    t_read();
    t_slot_write();
    t_protect();
    t_wp_timing();
    t_single_xfer();
    t_gang();
    t_step();
    t_illegal();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule